// File: doc/BRIEF.md
# Five-Segment Discontinuous Space-Vector Modulator

This block drives the three raw gate signals of a three-phase inverter bridge using a discontinuous space-vector scheme. In each PWM period one leg holds still and the other two are modulated. The legs are named a, b and c. A digital triangle carrier rises and falls between two fixed bounds. Two dwell thresholds arrive from an upstream calculator, already scaled to the carrier range: A is the first active time, and B is the sum of both active times. The carrier is compared against these thresholds, and a 3-bit sector number decides three things: which leg is clamped, which leg follows A, and which leg follows B.

In odd sectors the clamped leg sits at 1 and the compared legs go high above their thresholds. In even sectors the clamped leg sits at 0 and the compared legs go high below their thresholds. Over one period the bridge therefore walks through a symmetric five-state sequence with a single null vector in the middle: all-ones in odd sectors, all-zeros in even sectors.

The carrier moves only on a step enable, so the carrier frequency is set from outside. A one-clock strobe marks the start of each period. The thresholds are plain level inputs, sampled once per period at that boundary. There is no handshake and no back-pressure: the upstream source only needs to hold valid values at the edge that ends a period. Computing the dwell times and inserting dead time are handled elsewhere.

Top module: `svpwm_dsm`

## Requirements
- R1: The internal carrier starts at 224 after reset, rises in steps of 8 up to 352, then falls in steps of 8 back to 224. A full period is 32 steps (16 up, 16 down).
- R2: The carrier advances by one step only on a clock edge where `step_en` is 1. Otherwise it holds its value.
- R3: `period_start` is high for exactly one clock, the clock after the edge at which the carrier steps from 232 down to 224. It is low at all other times.
- R4: `thr_a_in` and `thr_b_in` are captured only at the edge that raises `period_start`. Changes at any other time have no effect on the legs until the next such edge. Both captured thresholds are 0 after reset.
- R5: In sectors 1, 3 and 5, the clamped leg is 1. A compared leg is 1 exactly when the carrier is strictly greater than its threshold.
- R6: In sectors 2, 4 and 6, the clamped leg is 0. A compared leg is 1 exactly when the carrier is strictly less than its threshold.
- R7: The leg roles per sector, written as (clamped, follows A, follows B), are: sector 1 = (a, b, c); sector 2 = (c, a, b); sector 3 = (b, c, a); sector 4 = (a, b, c); sector 5 = (c, a, b); sector 6 = (b, c, a).
- R8: A sector value of 0 or 7 drives all three legs to 0.
- R9: Each leg output is registered. On every clock it reflects the sector input, carrier and captured thresholds as they stood just before that edge. Reset (synchronous, active high) drives all legs and `period_start` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance the carrier by one step on this edge |
| sector | input | 3 | Sector number, 1 to 6 valid; 0 and 7 force all legs low |
| thr_a_in | input | 9 | First-switch threshold (active time A), carrier scale |
| thr_b_in | input | 9 | Second-switch threshold (A plus B), carrier scale |
| leg_a | output | 1 | Raw gate signal, leg a |
| leg_b | output | 1 | Raw gate signal, leg b |
| leg_c | output | 1 | Raw gate signal, leg c |
| period_start | output | 1 | One-clock strobe at the bottom of the carrier |

## Verification
Two things coincide at the carrier bottom: the capture of new thresholds and the leg decision made against the carrier at that same instant. A sector change can land on that edge too. The bench provokes this by changing A, B and the sector exactly on the boundary cycle and also in the middle of a period. It runs with the step enable both continuous and thinned, so the boundary edge sometimes follows an idle stretch. A behavioural model tracks the step index, the period boundary and the held thresholds as plain integers and predicts every leg and the strobe on each clock. Mid-period threshold changes must leave the legs untouched until the next strobe, and the new values must take effect from the strobe cycle onward.

// File: rtl/svpwm_pkg.sv
package svpwm_pkg;

  localparam int unsigned CAR_W   = 9;
  localparam int unsigned CAR_LO  = 224;
  localparam int unsigned CAR_HI  = 352;
  localparam int unsigned SAMPLES = 32;

  typedef enum logic [1:0] {
    ROLE_OFF   = 2'd0,
    ROLE_CLAMP = 2'd1,
    ROLE_CMP_A = 2'd2,
    ROLE_CMP_B = 2'd3
  } leg_role_e;

  // Role of leg (0=a, 1=b, 2=c) in a sector; the pattern repeats every
  // three sectors, only the clamp level and compare sense alternate.
  function automatic leg_role_e role_of(input logic [2:0] sec, input int leg);
    leg_role_e ra, rb, rc;
    case (sec)
      3'd1, 3'd4: begin ra = ROLE_CLAMP; rb = ROLE_CMP_A; rc = ROLE_CMP_B; end
      3'd2, 3'd5: begin ra = ROLE_CMP_A; rb = ROLE_CMP_B; rc = ROLE_CLAMP; end
      3'd3, 3'd6: begin ra = ROLE_CMP_B; rb = ROLE_CLAMP; rc = ROLE_CMP_A; end
      default:    begin ra = ROLE_OFF;   rb = ROLE_OFF;   rc = ROLE_OFF;   end
    endcase
    case (leg)
      0:       return ra;
      1:       return rb;
      default: return rc;
    endcase
  endfunction

endpackage

// File: rtl/svpwm_carrier.sv
module svpwm_carrier #(
  parameter int unsigned CW      = 9,
  parameter int unsigned LO      = 224,
  parameter int unsigned HI      = 352,
  parameter int unsigned SAMPLES = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_en,
  output logic [CW-1:0] car,
  output logic          wrap,
  output logic          strobe
);
  localparam int unsigned HALF = SAMPLES / 2;
  localparam int unsigned STEP = (HI - LO) / HALF;
  localparam logic [CW-1:0] LO_V   = CW'(LO);
  localparam logic [CW-1:0] HI_V   = CW'(HI);
  localparam logic [CW-1:0] STEP_V = CW'(STEP);

  logic rising;

  // Edge that brings the carrier back to its bottom value.
  assign wrap = step_en && !rising && (car == LO_V + STEP_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      car    <= LO_V;
      rising <= 1'b1;
      strobe <= 1'b0;
    end else begin
      strobe <= wrap;
      if (step_en) begin
        if (rising) begin
          car <= car + STEP_V;
          if (car + STEP_V == HI_V) rising <= 1'b0;
        end else begin
          car <= car - STEP_V;
          if (car - STEP_V == LO_V) rising <= 1'b1;
        end
      end
    end
  end

  AST_CARRIER_RANGE: assert property (@(posedge clk) disable iff (rst)
    (car >= LO_V) && (car <= HI_V)); // R1
  AST_CARRIER_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(car)); // R2
  AST_STROBE_BOTTOM: assert property (@(posedge clk) disable iff (rst)
    strobe |-> (car == LO_V)); // R3
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe); // R3

endmodule

// File: rtl/svpwm_thr_hold.sv
module svpwm_thr_hold #(
  parameter int unsigned CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic [CW-1:0] a_in,
  input  logic [CW-1:0] b_in,
  output logic [CW-1:0] a_q,
  output logic [CW-1:0] b_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else if (cap) begin
      a_q <= a_in;
      b_q <= b_in;
    end
  end

  AST_THR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !cap |=> ($stable(a_q) && $stable(b_q))); // R4

endmodule

// File: rtl/svpwm_leg_map.sv
module svpwm_leg_map
  import svpwm_pkg::*;
#(
  parameter int unsigned CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    sector,
  input  logic [CW-1:0] car,
  input  logic [CW-1:0] thr_a,
  input  logic [CW-1:0] thr_b,
  output logic [2:0]    legs   // [0]=a, [1]=b, [2]=c
);
  logic odd_sec;
  logic valid_sec;
  logic [2:0] legs_nxt;

  assign odd_sec   = sector[0];
  assign valid_sec = (sector != 3'd0) && (sector != 3'd7);

  for (genvar g = 0; g < 3; g++) begin : g_leg
    leg_role_e role;
    assign role = role_of(sector, g);
    always_comb begin
      case (role)
        ROLE_CLAMP: legs_nxt[g] = odd_sec;
        ROLE_CMP_A: legs_nxt[g] = odd_sec ? (car > thr_a) : (car < thr_a);
        ROLE_CMP_B: legs_nxt[g] = odd_sec ? (car > thr_b) : (car < thr_b);
        default:    legs_nxt[g] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) legs <= '0;
    else     legs <= legs_nxt;
  end

  AST_ODD_CLAMP_HIGH: assert property (@(posedge clk) disable iff (rst)
    (valid_sec && odd_sec) |=> ($countones(legs) >= 1)); // R5
  AST_EVEN_CLAMP_LOW: assert property (@(posedge clk) disable iff (rst)
    (valid_sec && !odd_sec) |=> ($countones(legs) <= 2)); // R6
  AST_BAD_SECTOR_LOW: assert property (@(posedge clk) disable iff (rst)
    !valid_sec |=> (legs == 3'b000)); // R8
  AST_SEC1_LEG_A: assert property (@(posedge clk) disable iff (rst)
    (sector == 3'd1) |=> legs[0]); // R7

endmodule

// File: rtl/svpwm_dsm.sv
module svpwm_dsm
  import svpwm_pkg::*;
#(
  parameter int unsigned CW      = CAR_W,
  parameter int unsigned LO      = CAR_LO,
  parameter int unsigned HI      = CAR_HI,
  parameter int unsigned SAMPLES = svpwm_pkg::SAMPLES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_en,
  input  logic [2:0]    sector,
  input  logic [CW-1:0] thr_a_in,
  input  logic [CW-1:0] thr_b_in,
  output logic          leg_a,
  output logic          leg_b,
  output logic          leg_c,
  output logic          period_start
);
  logic [CW-1:0] car;
  logic          wrap;
  logic [CW-1:0] thr_a_q, thr_b_q;
  logic [2:0]    legs;

  svpwm_carrier #(.CW(CW), .LO(LO), .HI(HI), .SAMPLES(SAMPLES)) u_car (
    .clk(clk), .rst(rst), .step_en(step_en),
    .car(car), .wrap(wrap), .strobe(period_start)
  );

  svpwm_thr_hold #(.CW(CW)) u_thr (
    .clk(clk), .rst(rst), .cap(wrap),
    .a_in(thr_a_in), .b_in(thr_b_in),
    .a_q(thr_a_q), .b_q(thr_b_q)
  );

  svpwm_leg_map #(.CW(CW)) u_map (
    .clk(clk), .rst(rst), .sector(sector), .car(car),
    .thr_a(thr_a_q), .thr_b(thr_b_q), .legs(legs)
  );

  assign leg_a = legs[0];
  assign leg_b = legs[1];
  assign leg_c = legs[2];

  AST_CAPTURE_AT_STROBE: assert property (@(posedge clk) disable iff (rst)
    !$stable(thr_a_q) |-> period_start); // R4

endmodule

// File: tb/tb_svpwm_dsm.sv
`timescale 1ns/1ps
module tb_svpwm_dsm;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst;
  logic       step_en;
  logic [2:0] sector;
  logic [8:0] thr_a_in, thr_b_in;
  logic       leg_a, leg_b, leg_c, period_start;

  svpwm_dsm dut (
    .clk(clk), .rst(rst), .step_en(step_en), .sector(sector),
    .thr_a_in(thr_a_in), .thr_b_in(thr_b_in),
    .leg_a(leg_a), .leg_b(leg_b), .leg_c(leg_c), .period_start(period_start)
  );

  int checks = 0, failures = 0, cycles = 0;
  bit checking = 0, done = 0;
  string tag = "R9";

  // Behavioural model state
  int k = 0;
  int m_a = 0, m_b = 0;
  bit [2:0] exp_legs = 0;   // [0]=a
  bit exp_strobe = 0;

  function automatic int car_of(int idx);
    return 224 + 8 * ((idx <= 16) ? idx : 32 - idx);
  endfunction

  function automatic bit [2:0] predict(int sec, int c, int ta, int tb);
    bit [2:0] r = 0;
    int clamp, la, lb;
    bit odd;
    if (sec < 1 || sec > 6) return 3'b000;
    odd   = (sec % 2) == 1;
    clamp = (3 - ((sec - 1) % 3)) % 3;
    la    = (clamp + 1) % 3;
    lb    = (clamp + 2) % 3;
    r[clamp] = odd;
    r[la] = odd ? (c > ta) : (c < ta);
    r[lb] = odd ? (c > tb) : (c < tb);
    return r;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      k = 0; m_a = 0; m_b = 0; exp_legs = 0; exp_strobe = 0;
    end else begin
      exp_legs   = predict(int'(sector), car_of(k), m_a, m_b);
      exp_strobe = step_en && (k == 31);
      if (step_en && k == 31) begin
        m_a = int'(thr_a_in);
        m_b = int'(thr_b_in);
      end
      if (step_en) k = (k + 1) % 32;
    end
  end

  always @(negedge clk) begin
    if (checking && !done) begin
      checks++;
      if ({leg_c, leg_b, leg_a} != exp_legs) begin
        failures++;
        $display("FAIL %s legs(cba)=%b expected=%b at cycle %0d", tag,
                 {leg_c, leg_b, leg_a}, {exp_legs[2], exp_legs[1], exp_legs[0]}, cycles);
      end
      checks++;
      if (period_start != exp_strobe) begin
        failures++;
        $display("FAIL R3 period_start=%b expected=%b at cycle %0d",
                 period_start, exp_strobe, cycles);
      end
    end
  end

  task automatic run(input int n, input int div);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      step_en = (div <= 1) ? 1'b1 : ((i % div) == 0);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst = 1; step_en = 0; sector = 3'd1; thr_a_in = 0; thr_b_in = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R9: reset state at the ports
    checks++;
    if ({leg_c, leg_b, leg_a} != 3'b000 || period_start != 1'b0) begin
      failures++;
      $display("FAIL R9 reset legs=%b strobe=%b expected=000/0",
               {leg_c, leg_b, leg_a}, period_start);
    end
    checking = 1;
    // R1, R5: continuous stepping, sector 1, thresholds zero then loaded
    tag = "R1"; thr_a_in = 9'd256; thr_b_in = 9'd320;
    run(70, 1);
    // R5/R7: odd sectors
    tag = "R5"; sector = 3'd3; run(32, 1);
    tag = "R7"; sector = 3'd5; thr_a_in = 9'd240; thr_b_in = 9'd336; run(64, 1);
    // R6/R7: even sectors
    tag = "R6"; sector = 3'd2; run(64, 1);
    tag = "R7"; sector = 3'd4; run(32, 1);
    sector = 3'd6; thr_a_in = 9'd280; thr_b_in = 9'd300; run(64, 1);
    // R5/R6 strictness: thresholds equal to carrier sample values and bounds
    tag = "R5"; sector = 3'd1; thr_a_in = 9'd232; thr_b_in = 9'd352; run(64, 1);
    tag = "R6"; sector = 3'd2; thr_a_in = 9'd224; thr_b_in = 9'd288; run(64, 1);
    // Equal thresholds
    tag = "R7"; sector = 3'd3; thr_a_in = 9'd296; thr_b_in = 9'd296; run(64, 1);
    // R2: thinned step enable
    tag = "R2"; sector = 3'd4; thr_a_in = 9'd248; thr_b_in = 9'd328; run(200, 3);
    run(150, 7);
    // R4: mid-period threshold changes have no effect until the boundary
    tag = "R4"; sector = 3'd5; run(10, 1);
    thr_a_in = 9'd350; thr_b_in = 9'd351; run(5, 1);
    thr_a_in = 9'd226; thr_b_in = 9'd230; run(60, 1);
    // Sector and thresholds changed around the boundary, thinned stepping
    sector = 3'd6; run(40, 2);
    thr_a_in = 9'd300; thr_b_in = 9'd340; sector = 3'd1; run(100, 2);
    // R8: invalid sectors
    tag = "R8"; sector = 3'd0; run(40, 1);
    sector = 3'd7; run(40, 1);
    // R9: sector changes on every clock
    tag = "R9";
    for (int s = 0; s < 48; s++) begin
      @(negedge clk);
      step_en = 1'b1;
      sector = 3'(s % 8);
    end
    run(4, 1);
    checking = 0;
    finish_run();
  end
endmodule